// File: doc/BRIEF.md
# NOR Flash Command and Identifier Control

This block is the control side of a small parallel NOR flash. It samples the active-low chip-enable, output-enable and write-enable strobes on a system clock. It counts a write only when the strobes show a legal write, and only on the first clock of that strobe combination. Accepted writes drive a command state machine. The state machine recognises three unlock-style sequences: one enters identifier mode, one programs a single location and one erases a whole sector. A reset byte aborts whichever of them is in progress.

While identifier mode is active, a read returns one of three things on the 8-bit data bus: the maker code, the device code or the protection status of one sector. The low address bits choose which, and the top address bits choose the sector. A per-sector protection bitmap is changed through a sideband port, which stands in for the high-voltage method used by programming equipment. Program and erase requests that target a protected sector are dropped.

A supply-lockout input keeps the command logic in read mode and discards every write for as long as it is high. The protection bitmap keeps its contents through a lockout.

Top module: `nor_autoselect_ctl`

## Requirements
- R1: A write is taken on the first clock at which ce_n=0, we_n=0 and oe_n=1 all hold. Holding that combination for further clocks adds no further writes.
- R2: No write is taken on a clock where oe_n=0, ce_n=1 or we_n=1. Such a cycle leaves the command state unchanged.
- R3: Identifier mode (auto_mode=1) is entered by three writes of address/data 555h/AAh, 2AAh/55h and 555h/90h. Only addr[10:0] is compared.
- R4: A write of F0h in any state returns the block to read mode. Any write that does not match the next step of a sequence also returns to read mode.
- R5: In identifier mode, a read with addr[6]=0, addr[1]=0 and addr[0]=0 returns the maker code 01h.
- R6: In identifier mode, a read with addr[6]=0, addr[1]=0 and addr[0]=1 returns the device code 6Eh.
- R7: In identifier mode, a read with addr[6]=0, addr[1]=1 and addr[0]=0 returns 01h if the sector in addr[16:14] is protected and 00h if it is not. All other low-bit codes return 00h.
- R8: rdata_oe and rdata are registered one clock after the read strobes are sampled. rdata_oe is 1 only in identifier mode with ce_n=0 and oe_n=0. Otherwise rdata is 00h.
- R9: After 555h/AAh, 2AAh/55h and 555h/A0h, the next write pulses pgm_go for one clock, carrying that write's address and data on op_addr and op_data. The pulse is suppressed when the target sector is protected.
- R10: The writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h and then 30h at any address in the target sector pulse ers_go for one clock, with op_addr set. The pulse is suppressed when the sector is protected, and no pulse follows any other final byte.
- R11: A clock with prot_wr=1 writes prot_val into the bit for sector prot_sect and changes no other bit. Clearing the bit allows program and erase of that sector again.
- R12: After reset every sector is unprotected, auto_mode is 0 and no pulse is raised.
- R13: While lockout=1 every write is ignored and the command state is held in read mode. Writes are accepted again once lockout has returned to 0, and the protection bitmap is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Byte address |
| wdata | input | 8 | Write data |
| lockout | input | 1 | Supply below lockout threshold |
| prot_wr | input | 1 | Sideband protection update strobe |
| prot_sect | input | 3 | Sector whose protection bit is written |
| prot_val | input | 1 | New protection bit value |
| rdata | output | 8 | Identifier or protection readout |
| rdata_oe | output | 1 | Readout is driven onto the bus |
| auto_mode | output | 1 | Identifier mode is active |
| pgm_go | output | 1 | One-clock program request |
| ers_go | output | 1 | One-clock sector erase request |
| op_addr | output | 17 | Address of the program or erase request |
| op_data | output | 8 | Data of the program request |

## Verification
A write whose strobes are sampled at one rising edge changes auto_mode, and pulses pgm_go or ers_go, at that same edge. The bench therefore drives every write for exactly one clock from a falling edge and reads those outputs at the very next falling edge. The pulses can be seen only at that falling edge. Readout is registered from the strobes of the edge at which it is sampled. Reads also hold their strobes for one clock and compare rdata and rdata_oe at the falling edge after it. A sideband protection update lands on the edge that samples it, so later reads and commands see it.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    typedef enum logic [2:0] {
        ST_READ, ST_UNL1, ST_UNL2, ST_AUTO, ST_PROG, ST_ERS1, ST_ERS2, ST_ERS3
    } cmd_state_e;

    localparam logic [7:0]  CMD_RESET   = 8'hF0;
    localparam logic [7:0]  CMD_UNLK_A  = 8'hAA;
    localparam logic [7:0]  CMD_UNLK_B  = 8'h55;
    localparam logic [7:0]  CMD_IDENT   = 8'h90;
    localparam logic [7:0]  CMD_PROG    = 8'hA0;
    localparam logic [7:0]  CMD_ERASE   = 8'h80;
    localparam logic [7:0]  CMD_SECT_ER = 8'h30;
    localparam logic [10:0] UNLK_ADDR_A = 11'h555;
    localparam logic [10:0] UNLK_ADDR_B = 11'h2AA;
endpackage

// File: rtl/nfc_wr_qual.sv
module nfc_wr_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic lockout,
    output logic wr_stb
);
    logic lvl;
    logic lvl_d, lvl_q;

    always_comb begin
        lvl   = !ce_n && !we_n && oe_n && !lockout;
        lvl_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign wr_stb = lvl && !lvl_q;

    AST_WR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R1
    AST_WR_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> !wr_stb); // R13
endmodule

// File: rtl/nfc_prot_map.sv
module nfc_prot_map #(
    parameter int SECT_W = 3,
    localparam int N_SECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_wr,
    input  logic [SECT_W-1:0] prot_sect,
    input  logic              prot_val,
    output logic [N_SECT-1:0] prot_vec
);
    logic [N_SECT-1:0] prot_d, prot_q;

    for (genvar i = 0; i < N_SECT; i++) begin : g_bit
        always_comb begin
            prot_d[i] = (prot_wr && (prot_sect == SECT_W'(i))) ? prot_val : prot_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prot_q <= '0;
        else        prot_q <= prot_d;
    end

    assign prot_vec = prot_q;

    AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_wr |=> $stable(prot_q)); // R11
    AST_PROT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr |=> $countones(prot_q ^ $past(prot_q)) <= 1); // R11
endmodule

// File: rtl/nfc_cmd_fsm.sv
module nfc_cmd_fsm
    import nfc_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int SECT_W = 3,
    localparam int N_SECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lockout,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [N_SECT-1:0] prot_vec,
    output logic              auto_mode,
    output logic              pgm_go,
    output logic              ers_go,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);
    typedef struct packed {
        cmd_state_e        state;
        logic              pgm;
        logic              ers;
        logic [ADDR_W-1:0] oaddr;
        logic [7:0]        odata;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic is_a, is_b, sect_prot;

    always_comb begin
        is_a      = (addr[10:0] == UNLK_ADDR_A);
        is_b      = (addr[10:0] == UNLK_ADDR_B);
        sect_prot = prot_vec[addr[ADDR_W-1 -: SECT_W]];
        fsm_d     = fsm_q;
        fsm_d.pgm = 1'b0;
        fsm_d.ers = 1'b0;
        if (lockout) begin
            fsm_d.state = ST_READ;
        end else if (wr_stb) begin
            if (wdata == CMD_RESET) begin
                fsm_d.state = ST_READ;
            end else begin
                unique case (fsm_q.state)
                    ST_READ, ST_AUTO:
                        fsm_d.state = (is_a && wdata == CMD_UNLK_A) ? ST_UNL1 : ST_READ;
                    ST_UNL1:
                        fsm_d.state = (is_b && wdata == CMD_UNLK_B) ? ST_UNL2 : ST_READ;
                    ST_UNL2: begin
                        if (is_a && wdata == CMD_IDENT)      fsm_d.state = ST_AUTO;
                        else if (is_a && wdata == CMD_PROG)  fsm_d.state = ST_PROG;
                        else if (is_a && wdata == CMD_ERASE) fsm_d.state = ST_ERS1;
                        else                                 fsm_d.state = ST_READ;
                    end
                    ST_PROG: begin
                        fsm_d.state = ST_READ;
                        fsm_d.pgm   = !sect_prot;
                        fsm_d.oaddr = addr;
                        fsm_d.odata = wdata;
                    end
                    ST_ERS1:
                        fsm_d.state = (is_a && wdata == CMD_UNLK_A) ? ST_ERS2 : ST_READ;
                    ST_ERS2:
                        fsm_d.state = (is_b && wdata == CMD_UNLK_B) ? ST_ERS3 : ST_READ;
                    ST_ERS3: begin
                        fsm_d.state = ST_READ;
                        if (wdata == CMD_SECT_ER) begin
                            fsm_d.ers   = !sect_prot;
                            fsm_d.oaddr = addr;
                        end
                    end
                    default: fsm_d.state = ST_READ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_READ, pgm: 1'b0, ers: 1'b0, oaddr: '0, odata: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign auto_mode = (fsm_q.state == ST_AUTO);
    assign pgm_go    = fsm_q.pgm;
    assign ers_go    = fsm_q.ers;
    assign op_addr   = fsm_q.oaddr;
    assign op_data   = fsm_q.odata;

    AST_LOCKOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> fsm_q.state == ST_READ); // R13
    AST_AUTO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(auto_mode) |-> $past(fsm_q.state) == ST_UNL2); // R3
    AST_PGM_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_go |-> !$past(prot_vec[addr[ADDR_W-1 -: SECT_W]])); // R9
    AST_ERS_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
        ers_go |-> !$past(prot_vec[addr[ADDR_W-1 -: SECT_W]])); // R10
    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(pgm_go && ers_go)); // R10
endmodule

// File: rtl/nor_autoselect_ctl.sv
module nor_autoselect_ctl #(
    parameter int         ADDR_W   = 17,
    parameter int         SECT_W   = 3,
    parameter logic [7:0] MFR_CODE = 8'h01,
    parameter logic [7:0] DEV_CODE = 8'h6E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              lockout,
    input  logic              prot_wr,
    input  logic [SECT_W-1:0] prot_sect,
    input  logic              prot_val,
    output logic [7:0]        rdata,
    output logic              rdata_oe,
    output logic              auto_mode,
    output logic              pgm_go,
    output logic              ers_go,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);
    localparam int N_SECT = 1 << SECT_W;

    typedef struct packed {
        logic [7:0] rd;
        logic       oe;
    } rdo_t;

    logic              wr_stb;
    logic [N_SECT-1:0] prot_vec;
    rdo_t              rdo_d, rdo_q;

    nfc_wr_qual u_qual (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .lockout(lockout), .wr_stb(wr_stb)
    );

    nfc_prot_map #(.SECT_W(SECT_W)) u_prot (
        .clk(clk), .rst_n(rst_n), .prot_wr(prot_wr), .prot_sect(prot_sect),
        .prot_val(prot_val), .prot_vec(prot_vec)
    );

    nfc_cmd_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .lockout(lockout), .wr_stb(wr_stb),
        .addr(addr), .wdata(wdata), .prot_vec(prot_vec),
        .auto_mode(auto_mode), .pgm_go(pgm_go), .ers_go(ers_go),
        .op_addr(op_addr), .op_data(op_data)
    );

    always_comb begin
        rdo_d.oe = auto_mode && !ce_n && !oe_n;
        rdo_d.rd = 8'h00;
        if (rdo_d.oe) begin
            unique case ({addr[6], addr[1], addr[0]})
                3'b000:  rdo_d.rd = MFR_CODE;
                3'b001:  rdo_d.rd = DEV_CODE;
                3'b010:  rdo_d.rd = {7'b0, prot_vec[addr[ADDR_W-1 -: SECT_W]]};
                default: rdo_d.rd = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdo_q <= '{rd: 8'h00, oe: 1'b0};
        else        rdo_q <= rdo_d;
    end

    assign rdata    = rdo_q.rd;
    assign rdata_oe = rdo_q.oe;

    AST_OE_NEEDS_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> $past(auto_mode)); // R8
    AST_OE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> $past(!ce_n && !oe_n)); // R8
endmodule

// File: tb/tb_nor_autoselect_ctl.sv
module tb_nor_autoselect_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        lockout = 1'b0;
    logic        prot_wr = 1'b0;
    logic [2:0]  prot_sect = '0;
    logic        prot_val = 1'b0;
    logic [7:0]  rdata;
    logic        rdata_oe, auto_mode, pgm_go, ers_go;
    logic [16:0] op_addr;
    logic [7:0]  op_data;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    logic [7:0] model_prot = '0;

    always #2 clk = ~clk;

    nor_autoselect_ctl dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .lockout(lockout), .prot_wr(prot_wr),
        .prot_sect(prot_sect), .prot_val(prot_val), .rdata(rdata),
        .rdata_oe(rdata_oe), .auto_mode(auto_mode), .pgm_go(pgm_go),
        .ers_go(ers_go), .op_addr(op_addr), .op_data(op_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_id(input logic [16:0] a, input logic [7:0] pm);
        case ({a[6], a[1], a[0]})
            3'b000:  return 8'h01;
            3'b001:  return 8'h6E;
            3'b010:  return {7'b0, pm[a[16:14]]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 0; we_n = 0; oe_n = 1; addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1; we_n = 1;
    endtask

    task automatic rd(input logic [16:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        @(negedge clk);
        d = rdata; oe = rdata_oe;
        ce_n = 1; oe_n = 1;
    endtask

    task automatic set_prot(input int s, input logic v);
        @(negedge clk);
        prot_wr = 1; prot_sect = 3'(s); prot_val = v;
        @(negedge clk);
        prot_wr = 0;
        model_prot[s] = v;
    endtask

    task automatic unlock();
        wr(17'h555, 8'hAA);
        wr(17'h2AA, 8'h55);
    endtask

    task automatic enter_auto();
        unlock();
        wr(17'h555, 8'h90);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic oe;
        logic [7:0] pats [5];
        pats[0] = 8'h00; pats[1] = 8'hA5; pats[2] = 8'h3C; pats[3] = 8'hFF; pats[4] = 8'h81;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12 auto_mode", auto_mode, 0);
        chk("R12 pgm_go", pgm_go, 0);
        chk("R12 ers_go", ers_go, 0);
        rd(17'h0, d, oe);
        chk("R8 oe outside autoselect", oe, 0);
        chk("R8 rdata outside autoselect", d, 0);

        enter_auto();
        chk("R3 entry", auto_mode, 1);
        for (int s = 0; s < 8; s++) begin
            rd({3'(s), 14'h2}, d, oe);
            chk("R12 sector unprotected after reset", d, 8'h00);
        end

        // Sweep protection patterns x sectors x low-bit codes: R5 R6 R7 R8
        for (int p = 0; p < 5; p++) begin
            for (int s = 0; s < 8; s++) set_prot(s, pats[p][s]);
            for (int s = 0; s < 8; s++) begin
                for (int c = 0; c < 8; c++) begin
                    logic [16:0] a;
                    a = {3'(s), 14'h0} | (17'(c >> 2) << 6) | 17'(c & 3) | (17'(s) << 8);
                    rd(a, d, oe);
                    chk("R8 oe in autoselect", oe, 1);
                    chk($sformatf("R5/R6/R7 code c=%0d s=%0d", c, s), d, exp_id(a, model_prot));
                end
            end
        end

        // R8 chip enable high: not driven
        @(negedge clk); ce_n = 1; oe_n = 0; addr = 17'h0;
        @(negedge clk);
        chk("R8 oe with ce_n high", rdata_oe, 0);
        chk("R8 rdata with ce_n high", rdata, 0);
        oe_n = 1;

        // R2 inhibited write attempts leave autoselect
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 0; wdata = 8'hF0;
        @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
        chk("R2 oe_n low inhibits", auto_mode, 1);
        @(negedge clk); ce_n = 1; we_n = 0; oe_n = 1; wdata = 8'hF0;
        @(negedge clk); we_n = 1;
        chk("R2 ce_n high inhibits", auto_mode, 1);
        @(negedge clk); ce_n = 0; we_n = 1; oe_n = 1; wdata = 8'hF0;
        @(negedge clk); ce_n = 1;
        chk("R2 we_n high inhibits", auto_mode, 1);

        // R4 reset byte and broken sequences
        wr(17'h0, 8'hF0);
        chk("R4 F0 leaves autoselect", auto_mode, 0);
        wr(17'h555, 8'hAA); wr(17'h2AA, 8'h56); wr(17'h555, 8'h90);
        chk("R4 bad data breaks sequence", auto_mode, 0);
        wr(17'h555, 8'hAA); wr(17'h2AB, 8'h55); wr(17'h555, 8'h90);
        chk("R4 bad address breaks sequence", auto_mode, 0);
        unlock(); wr(17'h555, 8'hF0); wr(17'h555, 8'h90);
        chk("R4 F0 mid sequence", auto_mode, 0);
        enter_auto();
        wr(17'h123, 8'h77);
        chk("R4 stray write leaves autoselect", auto_mode, 0);

        // R1 write held for several clocks counts once
        unlock();
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = 17'h555; wdata = 8'h90;
        repeat (3) @(negedge clk);
        ce_n = 1; we_n = 1;
        chk("R1 held strobe counts once", auto_mode, 1);
        wr(17'h0, 8'hF0);

        // R9 program per sector with pattern A5
        for (int s = 0; s < 8; s++) set_prot(s, pats[1][s]);
        for (int s = 0; s < 8; s++) begin
            logic [16:0] a;
            a = {3'(s), 14'h0123};
            unlock(); wr(17'h555, 8'hA0); wr(a, 8'h5A + 8'(s));
            chk($sformatf("R9 pgm_go sector %0d", s), pgm_go, !model_prot[s]);
            if (!model_prot[s]) begin
                chk("R9 op_addr", op_addr, a);
                chk("R9 op_data", op_data, 8'h5A + 8'(s));
            end
            @(negedge clk);
            chk("R9 pulse one clock", pgm_go, 0);
        end

        // R10 erase per sector
        for (int s = 0; s < 8; s++) begin
            logic [16:0] a;
            a = {3'(s), 14'h0040};
            unlock(); wr(17'h555, 8'h80); unlock(); wr(a, 8'h30);
            chk($sformatf("R10 ers_go sector %0d", s), ers_go, !model_prot[s]);
            if (!model_prot[s]) chk("R10 op_addr", op_addr, a);
        end
        unlock(); wr(17'h555, 8'h80); unlock(); wr({3'd1, 14'h0}, 8'h31);
        chk("R10 wrong final byte", ers_go, 0);

        // R11 unprotect re-enables program and erase on sector 0
        set_prot(0, 1'b0);
        unlock(); wr(17'h555, 8'hA0); wr(17'h00010, 8'h12);
        chk("R11 program after unprotect", pgm_go, 1);
        unlock(); wr(17'h555, 8'h80); unlock(); wr(17'h00000, 8'h30);
        chk("R11 erase after unprotect", ers_go, 1);
        set_prot(1, 1'b1);
        unlock(); wr(17'h555, 8'hA0); wr({3'd1, 14'h0}, 8'h12);
        chk("R11 program after protect", pgm_go, 0);

        // R13 lockout
        enter_auto();
        @(negedge clk); lockout = 1;
        @(negedge clk);
        chk("R13 lockout resets command state", auto_mode, 0);
        enter_auto();
        chk("R13 writes ignored during lockout", auto_mode, 0);
        @(negedge clk); lockout = 0;
        enter_auto();
        chk("R13 writes accepted after release", auto_mode, 1);
        for (int s = 0; s < 8; s++) begin
            rd({3'(s), 14'h2}, d, oe);
            chk("R13 bitmap kept through lockout", d, {7'b0, model_prot[s]});
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule